// File: doc/BRIEF.md
# Four-Lane Parallel Oscillator Mixer

This block is the front stage of a high-rate digital down-converter. A real sample stream that arrives at the full rate Fs is handed to it as groups of four consecutive samples, one group per lane clock (Fs/4). The block splits each group onto four lanes. A polyphase numerically controlled oscillator makes four consecutive cosine values and four consecutive sine values of the carrier on every lane clock. Each lane sample is multiplied by its matching carrier values, so every clock yields four in-phase and four quadrature products.

The oscillator keeps one 32-bit phase accumulator. It advances by four frequency steps for each accepted group. Each lane adds its own fixed offset, so the carrier may run faster than the lane clock. A frequency word and an initial-phase word are loaded together. A sync input restarts the carrier at the initial phase. Products are rounded and saturated to 16 bits, and a valid flag travels with the data through a fixed pipeline.

Top module: `quad_nco_mixer`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid is low and every lane of out_i and out_q reads zero. Reset clears the frequency word, the phase word and the accumulator.
- R2: Lane k of in_samp (bits 16k+15 down to 16k) is full-rate sample 4m+k of group m. Lane k of out_i (same bit position) is that sample times the cosine value of its phase, and lane k of out_q is that sample times the sine value.
- R3: The phase of lane k is (A + k*F + P) mod 2^32, where A is the accumulator, F the frequency word and P the phase word. Its top 10 bits form the index p. The sine value is round(32767*sin(2*pi*(p+0.5)/1024)), and the cosine value uses index (p+256) mod 1024.
- R4: The accumulator advances by 4*F only on cycles where in_valid is high. Idle cycles leave the carrier phase of the next group unchanged.
- R5: Frequency words above 2^30, which put the carrier above the lane clock, still give the correct full-rate carrier samples on every lane.
- R6: Each 32-bit signed product is rounded as (prod + 2^14) arithmetically shifted right by 15 and then saturated to 16-bit signed. With the 32767 carrier amplitude, no output lane ever equals -32768.
- R7: A group accepted on the clock edge where in_valid is high shows up on the outputs after exactly 5 rising edges, counting that edge, with out_valid high for that one cycle. Every accepted group comes out once, in order.
- R8: When cfg_we is high on an edge, cfg_freq and cfg_phase are both captured. They apply to all four lanes of every group accepted on later edges. The group on that same edge uses the old words, and the accumulator keeps its value.
- R9: A group accepted with sync high uses accumulator value 0. Sync without in_valid sets the accumulator to 0 for the next group. Later groups continue from there.
- R10: While out_valid is low, out_i and out_q hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock (Fs/4) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group of four samples present |
| in_samp | input | 64 | Four signed samples, lane k in bits 16k+15:16k |
| sync | input | 1 | Restart carrier at the initial phase |
| cfg_we | input | 1 | Load frequency and phase words |
| cfg_freq | input | 32 | Frequency word (phase step per full-rate sample) |
| cfg_phase | input | 32 | Initial-phase word |
| out_valid | output | 1 | out_i/out_q carry a new group |
| out_i | output | 64 | Four signed in-phase products, lane k in bits 16k+15:16k |
| out_q | output | 64 | Four signed quadrature products, lane k in bits 16k+15:16k |

## Verification
The hardest case to reach from the ports is a phase word and a frequency word that change while groups are in flight, mixed with idle cycles and sync pulses. The accumulator is never visible directly, so any slip of one group or one lane offset only shows up as wrong carrier values many cycles later. The stimulus interleaves configuration writes, gap cycles and sync pulses with a running model of the accumulator. It also uses a frequency word above a quarter turn, where a lane-rate oscillator would alias. Full-scale samples set against the carrier peaks drive the rounding to its limits.

// File: rtl/pnm_pkg.sv
package pnm_pkg;

  localparam real PNM_PI = 3.14159265358979323846;

  // Magnitude of one quarter-wave entry; the half-step offset makes the
  // four quadrants exact mirrors of each other.
  function automatic int qwave_entry(input int idx, input int addr_w, input int amp);
    real ang;
    ang = 2.0 * PNM_PI * (real'(idx) + 0.5) / real'(4 * (1 << addr_w));
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

  // Quadrant decode of a table index: mirror the address, negate the value.
  typedef struct packed {
    logic neg;
    logic mirror;
  } quad_t;

endpackage

// File: rtl/pnm_qsine_rom.sv
module pnm_qsine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int AMP    = 32767
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(pnm_pkg::qwave_entry(i, ADDR_W, AMP));
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pnm_phase_gen.sv
module pnm_phase_gen #(
  parameter int LANES = 4,
  parameter int PH_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   sync,
  input  logic                   cfg_we,
  input  logic [PH_W-1:0]        cfg_freq,
  input  logic [PH_W-1:0]        cfg_phase,
  output logic [LANES*IDX_W-1:0] lane_idx
);
  localparam int SHIFT = PH_W - IDX_W;

  logic [PH_W-1:0] acc_q;
  logic [PH_W-1:0] freq_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] acc_eff;
  logic [PH_W-1:0] group_step;

  assign acc_eff    = sync ? '0 : acc_q;
  assign group_step = freq_q * PH_W'(LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      freq_q  <= '0;
      phase_q <= '0;
    end else begin
      acc_q <= adv ? acc_eff + group_step : acc_eff;
      if (cfg_we) begin
        freq_q  <= cfg_freq;
        phase_q <= cfg_phase;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PH_W-1:0]  ph;
    logic [IDX_W-1:0] idx_q;

    assign ph = acc_eff + freq_q * PH_W'(k) + phase_q;

    always_ff @(posedge clk) begin
      if (rst) idx_q <= '0;
      else     idx_q <= IDX_W'(ph >> SHIFT);
    end

    assign lane_idx[k*IDX_W +: IDX_W] = idx_q;
  end
endmodule

// File: rtl/pnm_carrier_lut.sv
module pnm_carrier_lut #(
  parameter int IDX_W = 10,
  parameter int CAR_W = 16,
  parameter int AMP   = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        sin_idx,
  output logic signed [CAR_W-1:0] sin_val,
  output logic signed [CAR_W-1:0] cos_val
);
  localparam int ADDR_W  = IDX_W - 2;
  localparam int QUARTER = 1 << ADDR_W;

  logic signed [CAR_W-1:0] car_val [2];

  // Branch 0 is sine, branch 1 is cosine (index shifted by a quarter turn).
  for (genvar g = 0; g < 2; g++) begin : g_branch
    logic [IDX_W-1:0]  idx;
    pnm_pkg::quad_t    quad;
    logic [ADDR_W-1:0] addr;
    logic [CAR_W-1:0]  mag;
    logic              neg_q;
    logic signed [CAR_W-1:0] val_q;

    assign idx  = (g == 0) ? sin_idx : sin_idx + IDX_W'(QUARTER);
    assign quad = pnm_pkg::quad_t'(idx[IDX_W-1 -: 2]);
    assign addr = quad.mirror ? ~idx[ADDR_W-1:0] : idx[ADDR_W-1:0];

    pnm_qsine_rom #(
      .ADDR_W (ADDR_W),
      .DATA_W (CAR_W),
      .AMP    (AMP)
    ) u_rom (
      .clk   (clk),
      .addr  (addr),
      .rdata (mag)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        neg_q <= 1'b0;
        val_q <= '0;
      end else begin
        neg_q <= quad.neg;
        val_q <= neg_q ? -$signed(mag) : $signed(mag);
      end
    end

    assign car_val[g] = val_q;
  end

  assign sin_val = car_val[0];
  assign cos_val = car_val[1];
endmodule

// File: rtl/pnm_lane_mix.sv
module pnm_lane_mix #(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_out,
  input  logic signed [SW-1:0] samp,
  input  logic signed [CW-1:0] car,
  output logic signed [OW-1:0] result
);
  localparam int PW   = SW + CW;
  localparam int FRAC = CW - 1;
  localparam logic signed [PW:0] RND  = (PW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [PW:0] OMAX = {{(PW-OW+2){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [PW:0] OMIN = {{(PW-OW+2){1'b1}}, {(OW-1){1'b0}}};

  logic signed [PW-1:0] prod_q;
  logic signed [PW:0]   sum;
  logic signed [PW:0]   shifted;
  logic signed [OW-1:0] sat;

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= samp * car;
  end

  assign sum     = {prod_q[PW-1], prod_q} + RND;
  assign shifted = sum >>> FRAC;

  always_comb begin
    if (shifted > OMAX)      sat = OMAX[OW-1:0];
    else if (shifted < OMIN) sat = OMIN[OW-1:0];
    else                     sat = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         result <= '0;
    else if (en_out) result <= sat;
  end
endmodule

// File: rtl/quad_nco_mixer.sv
module quad_nco_mixer #(
  parameter int LANES  = 4,
  parameter int SAMP_W = 16,
  parameter int PH_W   = 32,
  parameter int IDX_W  = 10,
  parameter int CAR_W  = 16,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*SAMP_W-1:0] in_samp,
  input  logic                    sync,
  input  logic                    cfg_we,
  input  logic [PH_W-1:0]         cfg_freq,
  input  logic [PH_W-1:0]         cfg_phase,
  output logic                    out_valid,
  output logic [LANES*OUT_W-1:0]  out_i,
  output logic [LANES*OUT_W-1:0]  out_q
);
  localparam int AMP      = (1 << (CAR_W - 1)) - 1;
  localparam int SAMP_DLY = 3;   // phase reg + table read + sign stage
  localparam int VSTAGES  = 4;   // stages ahead of the output register

  logic [LANES*IDX_W-1:0]  lane_idx;
  logic [LANES*SAMP_W-1:0] samp_dly [SAMP_DLY];
  logic [VSTAGES-1:0]      v_q;

  pnm_phase_gen #(
    .LANES (LANES),
    .PH_W  (PH_W),
    .IDX_W (IDX_W)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .adv       (in_valid),
    .sync      (sync),
    .cfg_we    (cfg_we),
    .cfg_freq  (cfg_freq),
    .cfg_phase (cfg_phase),
    .lane_idx  (lane_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= '0;
      out_valid <= 1'b0;
      for (int i = 0; i < SAMP_DLY; i++) samp_dly[i] <= '0;
    end else begin
      v_q         <= {v_q[VSTAGES-2:0], in_valid};
      out_valid   <= v_q[VSTAGES-1];
      samp_dly[0] <= in_samp;
      for (int i = 1; i < SAMP_DLY; i++) samp_dly[i] <= samp_dly[i-1];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [CAR_W-1:0]  sin_v;
    logic signed [CAR_W-1:0]  cos_v;
    logic signed [SAMP_W-1:0] x;
    logic signed [OUT_W-1:0]  i_res;
    logic signed [OUT_W-1:0]  q_res;

    assign x = samp_dly[SAMP_DLY-1][k*SAMP_W +: SAMP_W];

    pnm_carrier_lut #(
      .IDX_W (IDX_W),
      .CAR_W (CAR_W),
      .AMP   (AMP)
    ) u_lut (
      .clk     (clk),
      .rst     (rst),
      .sin_idx (lane_idx[k*IDX_W +: IDX_W]),
      .sin_val (sin_v),
      .cos_val (cos_v)
    );

    pnm_lane_mix #(
      .SW (SAMP_W),
      .CW (CAR_W),
      .OW (OUT_W)
    ) u_mix_i (
      .clk    (clk),
      .rst    (rst),
      .en_out (v_q[VSTAGES-1]),
      .samp   (x),
      .car    (cos_v),
      .result (i_res)
    );

    pnm_lane_mix #(
      .SW (SAMP_W),
      .CW (CAR_W),
      .OW (OUT_W)
    ) u_mix_q (
      .clk    (clk),
      .rst    (rst),
      .en_out (v_q[VSTAGES-1]),
      .samp   (x),
      .car    (sin_v),
      .result (q_res)
    );

    assign out_i[k*OUT_W +: OUT_W] = i_res;
    assign out_q[k*OUT_W +: OUT_W] = q_res;
  end
endmodule

// File: rtl/pnm_mixer_chk.sv
module pnm_mixer_chk #(
  parameter int LANES = 4,
  parameter int OUT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [LANES*OUT_W-1:0] out_i,
  input logic [LANES*OUT_W-1:0] out_q
);
  localparam int LAT = 5;

  logic [LAT-1:0] vtrack;
  logic           rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) vtrack <= '0;
    else     vtrack <= {vtrack[LAT-2:0], in_valid};
  end

  function automatic logic has_min(input logic [LANES*OUT_W-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (v[k*OUT_W +: OUT_W] == {1'b1, {(OUT_W-1){1'b0}}}) hit = 1'b1;
    end
    return hit;
  endfunction

  always_ff @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_CLEAR: assert (!out_valid && out_i == '0 && out_q == '0); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vtrack[LAT-1]); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q))); // R10

  AST_SYM_RANGE: assert property (@(posedge clk) disable iff (rst)
    !has_min(out_i) && !has_min(out_q)); // R6
endmodule

bind quad_nco_mixer pnm_mixer_chk #(
  .LANES (LANES),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/test_quad_nco_mixer.sv
`timescale 1ns/1ps
module test_quad_nco_mixer;
  localparam real PI = 3.14159265358979323846;
  localparam int  NE = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_samp = '0;
  logic        sync = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_freq = '0;
  logic [31:0] cfg_phase = '0;
  logic        out_valid;
  logic [63:0] out_i;
  logic [63:0] out_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    exp_i [NE][4];
  int    exp_q [NE][4];
  string etag  [NE];
  int    ecyc  [NE];
  int    head = 0;
  int    tail = 0;

  logic [31:0] acc_m = '0;
  logic [31:0] f_m = '0;
  logic [31:0] p_m = '0;
  logic [63:0] last_i = '0;
  logic [63:0] last_q = '0;
  bit          mon_on = 1'b0;

  quad_nco_mixer i_quad_nco_mixer (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_samp   (in_samp),
    .sync      (sync),
    .cfg_we    (cfg_we),
    .cfg_freq  (cfg_freq),
    .cfg_phase (cfg_phase),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_sin(input int p);
    real v;
    v = 32767.0 * $sin(2.0 * PI * (real'(p % 1024) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int ref_mix(input int x, input int c);
    longint pr;
    longint r;
    pr = longint'(x) * longint'(c);
    r  = (pr + 64'sd16384) >>> 15;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic drive(input bit v, input logic [63:0] w, input bit s,
                       input bit we, input logic [31:0] f, input logic [31:0] p,
                       input string tag);
    logic [31:0] acc_eff;
    @(negedge clk);
    in_valid = v; in_samp = w; sync = s;
    cfg_we = we; cfg_freq = f; cfg_phase = p;
    acc_eff = s ? 32'd0 : acc_m;
    if (v) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] ph;
        int x, p10;
        ph  = acc_eff + f_m * k + p_m;
        p10 = int'(ph[31:22]);
        x   = int'($signed(w[k*16 +: 16]));
        exp_i[tail][k] = ref_mix(x, ref_sin(p10 + 256));
        exp_q[tail][k] = ref_mix(x, ref_sin(p10));
      end
      etag[tail] = tag;
      ecyc[tail] = cyc;
      tail++;
    end
    acc_m = acc_eff + (v ? f_m * 4 : 32'd0);
    if (we) begin
      f_m = f;
      p_m = p;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0, '0, "");
  endtask

  task automatic drain(input string tag);
    idle(8);
    checks++;
    if (head != tail) begin
      errors++;
      $display("FAIL %s/R7 groups out %0d expected %0d", tag, head, tail);
    end
  endtask

  function automatic logic [63:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        checks++;
        if (head == tail) begin
          errors++;
          $display("FAIL R7 out_valid with no group pending: actual 1 expected 0");
        end else begin
          bit bad;
          bad = 1'b0;
          for (int k = 0; k < 4; k++) begin
            int ai, aq;
            ai = int'($signed(out_i[k*16 +: 16]));
            aq = int'($signed(out_q[k*16 +: 16]));
            if (ai != exp_i[head][k] || aq != exp_q[head][k]) begin
              bad = 1'b1;
              $display("FAIL %s group %0d lane %0d: I %0d Q %0d expected I %0d Q %0d",
                       etag[head], head, k, ai, aq, exp_i[head][k], exp_q[head][k]);
            end
          end
          if (cyc - ecyc[head] != 5) begin
            bad = 1'b1;
            $display("FAIL R7 latency of group %0d: actual %0d expected 5",
                     head, cyc - ecyc[head]);
          end
          if (bad) errors++;
          head++;
        end
      end else begin
        checks++;
        if (out_i != last_i || out_q != last_q) begin
          errors++;
          $display("FAIL R10 outputs moved while idle: I %h Q %h expected I %h Q %h",
                   out_i, out_q, last_i, last_q);
        end
      end
    end
    last_i = out_i;
    last_q = out_q;
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      errors++;
      $display("FAIL R1 during reset: valid %b I %h Q %h expected 0 0 0",
               out_valid, out_i, out_q);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      errors++;
      $display("FAIL R1 after reset: valid %b I %h Q %h expected 0 0 0",
               out_valid, out_i, out_q);
    end
    mon_on = 1'b1;
  endtask

  task automatic t_basic();
    drive(0, '0, 1, 1, 32'h0123_4567, 32'h0, "R2");
    for (int i = 0; i < 16; i++) drive(1, rnd_word(), 0, 0, '0, '0, "R2/R3");
    drain("R3");
  endtask

  task automatic t_high_freq();
    drive(0, '0, 1, 1, 32'h5A31_0F07, 32'h1000_0000, "R5");
    for (int i = 0; i < 16; i++) drive(1, rnd_word(), 0, 0, '0, '0, "R5");
    drain("R5");
  endtask

  task automatic t_gaps();
    drive(0, '0, 1, 1, 32'h0765_4321, 32'h2222_0000, "R4");
    for (int i = 0; i < 12; i++) begin
      drive(1, rnd_word(), 0, 0, '0, '0, "R4");
      idle(i % 3);
    end
    drain("R4");
  endtask

  task automatic t_cfg();
    drive(0, '0, 1, 1, 32'h0200_0000, 32'h0, "R8");
    for (int i = 0; i < 20; i++) begin
      if (i == 6)       drive(1, rnd_word(), 0, 1, 32'h3100_0001, 32'h8000_0000, "R8");
      else if (i == 13) drive(1, rnd_word(), 0, 1, 32'h0000_0000, 32'h4321_8765, "R8");
      else              drive(1, rnd_word(), 0, 0, '0, '0, "R8");
    end
    drain("R8");
  endtask

  task automatic t_sync();
    drive(0, '0, 0, 1, 32'h0A0B_0C0D, 32'h1357_0000, "R9");
    for (int i = 0; i < 12; i++) begin
      if (i == 4)      drive(1, rnd_word(), 1, 0, '0, '0, "R9");
      else if (i == 8) begin
        drive(0, '0, 1, 0, '0, '0, "R9");
        drive(1, rnd_word(), 0, 0, '0, '0, "R9");
      end else         drive(1, rnd_word(), 0, 0, '0, '0, "R9");
    end
    drain("R9");
  endtask

  task automatic t_full_scale();
    logic [63:0] w;
    w = {16'sh7FFF, 16'sh8000, 16'sh8000, 16'sh7FFF};
    drive(0, '0, 1, 1, 32'h0, 32'h3FC0_0000, "R6");
    drive(1, w, 0, 0, '0, '0, "R6");
    drive(1, 64'h8000_8000_8000_8000, 0, 1, 32'h0, 32'hBFC0_0000, "R6");
    drive(1, w, 0, 0, '0, '0, "R6");
    drive(1, 64'h7FFF_7FFF_7FFF_7FFF, 0, 1, 32'h0, 32'h0000_0000, "R6");
    drive(1, 64'h0001_FFFF_0002_FFFE, 0, 0, '0, '0, "R6");
    drain("R6");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_high_freq();
    t_gaps();
    t_cfg();
    t_sync();
    t_full_scale();
    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule